// File: doc/BRIEF.md
# Four-Phase Half-Coupled Pipeline Latch Controller

This block is a clock-driven, cycle-level model of a controller for one stage of an asynchronous pipeline, and of a FIFO built by chaining several such stages. Each stage sits between two return-to-zero, four-phase handshakes. A request rising means "data offered" and an acknowledge rising means "data taken". The falling edges only return both lines to zero.

Each stage keeps one internal state bit. That bit closes the stage's data latch and drives the stage's input acknowledge. While the bit is low the data register follows its input, and while it is high the register holds. A stage can close on a new item before the stage after it has finished its return to zero. A stalled output therefore lets every stage hold an item. The return-to-zero phases of the two sides of a stage stay linked: a stage cannot drop its input acknowledge until its output acknowledge has risen.

Each control line is a flop. It is updated once per clock from set and reset conditions, so a line changes at most once per cycle.

Top module: `hs4_latch_fifo`

## Requirements
- R1: After reset, `in_ack` and `out_req` are 0 and `out_data` is all zeros, with every stage empty.
- R2: `in_ack` rises only in the cycle after `in_req` was seen high. It falls only in the cycle after `in_req` was seen low. A stage whose state bit is high has captured its item.
- R3: `out_req` rises only after the last stage has captured an item. At that rise, `out_data` carries that item.
- R4: Items leave at `out_data` in the order they were accepted at `in_data`, with none lost and none duplicated.
- R5: While a stage holds an item, changes on its data input are ignored. `out_data` stays stable while `out_req` is high and `out_ack` is low.
- R6: With `out_ack` held low, the FIFO accepts DEPTH items (`in_ack` rises DEPTH times). The first of them is presented at `out_data` with `out_req` high.
- R7: With DEPTH items held and the output stalled, `in_ack` for the last item stays high after `in_req` falls. It falls only once the sink starts to drain.
- R8: A stage's input acknowledge falls only after its output acknowledge has been seen high. In a single-stage FIFO, `in_ack` stays high while `out_ack` stays low.
- R9: Once `out_req` has fallen, a stage may accept a new item (`in_ack` rises) while `out_ack` is still high.
- R10: `out_req` rises only in a cycle after `out_ack` was seen low, and falls only in a cycle after `out_ack` was seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_req | input | 1 | Input request, active on rising edge |
| in_ack | output | 1 | Input acknowledge, equal to the first stage's state bit |
| in_data | input | WIDTH | Input data, valid while `in_req` is high |
| out_req | output | 1 | Output request from the last stage |
| out_ack | input | 1 | Output acknowledge from the sink |
| out_data | output | WIDTH | Data held by the last stage |

## Verification
The hardest situation to reach is a FIFO that is completely full. In that state the first stage has closed on the final item but cannot raise its own output request, because its neighbour still acknowledges. The bench reaches it by stalling the sink and pushing DEPTH items. It then watches the last item's acknowledge stay high until the sink is released.

The linked return-to-zero phases and the early capture need a second condition: `out_ack` held at one level while the input side moves. They are driven by hand on a one-stage instance, with `out_ack` held low and then held high across a new capture.

// File: rtl/hs4_pkg.sv
package hs4_pkg;
  // Control state of one stage: latch-close bit and output request.
  typedef struct packed {
    logic a;
    logic rout;
  } hs4_ctrl_t;

  localparam hs4_ctrl_t HS4_IDLE = '{a: 1'b0, rout: 1'b0};
endpackage

// File: rtl/hs4_rst_sync.sv
module hs4_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/hs4_ctrl.sv
module hs4_ctrl
  import hs4_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rin_i,
  input  logic aout_i,
  output logic ain_o,
  output logic lt_o,
  output logic rout_o
);
  hs4_ctrl_t cur_q;
  hs4_ctrl_t nxt;

  // Next-state: set/reset style, hold otherwise.
  always_comb begin
    nxt = cur_q;
    if (rin_i && !cur_q.rout) begin
      nxt.a = 1'b1;
    end else if (!rin_i && cur_q.rout && aout_i) begin
      nxt.a = 1'b0;
    end
    if (cur_q.a && !aout_i) begin
      nxt.rout = 1'b1;
    end else if (!cur_q.a) begin
      nxt.rout = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= HS4_IDLE;
    end else begin
      cur_q <= nxt;
    end
  end

  assign ain_o  = cur_q.a;
  assign lt_o   = cur_q.a;
  assign rout_o = cur_q.rout;

  // R8: the input side returns to zero only after the output acknowledge is high
  assert_ain_fall_after_aout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ain_o) |-> ($past(aout_i) && $past(rout_o)));

  // R3: output request rises only once the stage has closed on an item
  assert_rout_after_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rout_o) |-> $past(lt_o));

  // R2: capture only follows a seen request
  assert_capture_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lt_o) |-> $past(rin_i));
endmodule

// File: rtl/hs4_latch.sv
module hs4_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lt_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic             load_en;
  logic [WIDTH-1:0] q_q;

  assign load_en = !lt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else if (load_en) begin
      q_q <= d_i;
    end
  end

  assign q_o = q_q;

  // R5: a closed latch keeps its contents
  assert_hold_while_closed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lt_i) |-> $stable(q_o));
endmodule

// File: rtl/hs4_latch_fifo.sv
module hs4_latch_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_req,
  output logic             in_ack,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_req,
  input  logic             out_ack,
  output logic [WIDTH-1:0] out_data
);
  localparam int NLINK = DEPTH + 1;

  logic                 rst_s;
  logic [NLINK-1:0]     req_w;
  logic [NLINK-1:0]     ack_w;
  logic [DEPTH-1:0]     lt_w;
  logic [WIDTH-1:0]     dat_w [NLINK];

  hs4_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_s)
  );

  assign req_w[0]     = in_req;
  assign ack_w[DEPTH] = out_ack;
  assign dat_w[0]     = in_data;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    hs4_ctrl u_ctrl (
      .clk_i  (clk_i),
      .rst_ni (rst_s),
      .rin_i  (req_w[s]),
      .aout_i (ack_w[s+1]),
      .ain_o  (ack_w[s]),
      .lt_o   (lt_w[s]),
      .rout_o (req_w[s+1])
    );

    hs4_latch #(.WIDTH(WIDTH)) u_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_s),
      .lt_i   (lt_w[s]),
      .d_i    (dat_w[s]),
      .q_o    (dat_w[s+1])
    );
  end

  assign in_ack   = ack_w[0];
  assign out_req  = req_w[DEPTH];
  assign out_data = dat_w[DEPTH];

  // R10: output request moves only in step with the sink acknowledge
  assert_out_req_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_s)
    $rose(out_req) |-> !$past(out_ack));
  assert_out_req_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_s)
    $fell(out_req) |-> $past(out_ack));

  // R2: input acknowledge tracks the request it answers
  assert_in_ack_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_s)
    $rose(in_ack) |-> $past(in_req));
  assert_in_ack_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_s)
    $fell(in_ack) |-> !$past(in_req));
endmodule

// File: tb/test_hs4_latch_fifo.sv
`timescale 1ns/1ps
module test_hs4_latch_fifo;
  localparam int W = 8;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         in_req = 1'b0, out_ack = 1'b0;
  logic         in_ack, out_req;
  logic [W-1:0] in_data = '0, out_data;

  logic         s_in_req = 1'b0, s_out_ack = 1'b0;
  logic         s_in_ack, s_out_req;
  logic [W-1:0] s_in_data = '0, s_out_data;

  hs4_latch_fifo #(.WIDTH(W), .DEPTH(D)) i_hs4_latch_fifo (
    .clk_i(clk), .rst_ni(rst_n), .in_req(in_req), .in_ack(in_ack), .in_data(in_data),
    .out_req(out_req), .out_ack(out_ack), .out_data(out_data));

  hs4_latch_fifo #(.WIDTH(W), .DEPTH(1)) i_hs4_latch_fifo_single (
    .clk_i(clk), .rst_ni(rst_n), .in_req(s_in_req), .in_ack(s_in_ack), .in_data(s_in_data),
    .out_req(s_out_req), .out_ack(s_out_ack), .out_data(s_out_data));

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  bit stall = 1'b0;
  bit mon_en = 1'b0;
  int src_max = 3;
  int snk_max = 3;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  // Driver: offer one item; optionally finish the return to zero.
  task automatic push(input logic [W-1:0] v, input bit finish_it);
    repeat ($urandom_range(0, src_max)) @(negedge clk);
    in_data = v;
    in_req  = 1'b1;
    for (int k = 0; k < 400 && in_ack !== 1'b1; k++) @(negedge clk);
    check(in_ack === 1'b1, "R2", "in_ack rise after in_req", in_ack, 1);
    exp_q.push_back(v);
    @(negedge clk);
    in_req = 1'b0;
    if (finish_it) begin
      for (int k = 0; k < 400 && in_ack !== 1'b0; k++) @(negedge clk);
      check(in_ack === 1'b0, "R2", "in_ack fall after in_req low", in_ack, 0);
    end
  endtask

  task automatic drain_wait();
    for (int k = 0; k < 4000 && exp_q.size() != 0; k++) @(negedge clk);
    check(exp_q.size() == 0, "R4", "all items delivered", exp_q.size(), 0);
    repeat (10) @(negedge clk);
  endtask

  // Monitor/sink: pops the scoreboard as items appear.
  initial begin
    forever begin
      @(negedge clk);
      if (out_req === 1'b1 && !stall) begin
        repeat ($urandom_range(0, snk_max)) @(negedge clk);
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected item", out_data, 0);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          check(out_data === e, "R4", "item order", out_data, e);
        end
        out_ack = 1'b1;
        while (out_req !== 1'b0) @(negedge clk);
        repeat ($urandom_range(0, snk_max)) @(negedge clk);
        out_ack = 1'b0;
      end
    end
  end

  // Protocol monitor: pre-edge snapshot, compared after the edge.
  logic snap_ack, snap_req, snap_ireq, snap_iack;
  logic [W-1:0] snap_data;
  always @(posedge clk) begin
    snap_ack  <= out_ack;
    snap_req  <= out_req;
    snap_data <= out_data;
    snap_ireq <= in_req;
    snap_iack <= in_ack;
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (out_req !== snap_req)
        check(out_req ? (snap_ack === 1'b0) : (snap_ack === 1'b1), "R10",
              "out_req moved against out_ack", snap_ack, out_req ? 0 : 1);
      if (out_req === 1'b1 && snap_req === 1'b1 && snap_ack === 1'b0)
        check(out_data === snap_data, "R5", "out_data stable while offered", out_data, snap_data);
      if (in_ack !== snap_iack)
        check(in_ack === snap_ireq, "R2", "in_ack follows in_req", in_ack, snap_ireq);
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(in_ack === 1'b0, "R1", "in_ack after reset", in_ack, 0);
    check(out_req === 1'b0, "R1", "out_req after reset", out_req, 0);
    check(out_data === '0, "R1", "out_data after reset", out_data, 0);
    check(s_in_ack === 1'b0 && s_out_req === 1'b0, "R1", "single stage idle", s_out_req, 0);
    mon_en = 1'b1;

    // R4 random stream
    for (int i = 0; i < 40; i++) push(W'($urandom_range(0, 255)), 1'b1);
    drain_wait();

    // R6/R7 fill with stalled sink
    stall = 1'b1;
    for (int i = 0; i < D - 1; i++) push(W'(8'h10 + i), 1'b1);
    push(W'(8'h10 + D - 1), 1'b0);
    check(exp_q.size() == D, "R6", "items accepted while stalled", exp_q.size(), D);
    repeat (30) @(negedge clk);
    check(in_ack === 1'b1, "R7", "last ack held while full", in_ack, 1);
    check(out_req === 1'b1, "R6", "first item offered", out_req, 1);
    check(out_data === 8'h10, "R6", "first item at output", out_data, 8'h10);
    stall = 1'b0;
    for (int k = 0; k < 400 && in_ack !== 1'b0; k++) @(negedge clk);
    check(in_ack === 1'b0, "R7", "ack released on drain", in_ack, 0);
    drain_wait();

    // R4 back-to-back stream
    src_max = 0;
    snk_max = 0;
    for (int i = 0; i < 30; i++) push(W'(8'hC0 ^ (i * 7)), 1'b1);
    drain_wait();

    // Single-stage: R8 coupling, R5 hold, R9 early capture
    @(negedge clk);
    s_in_data = 8'hA5;
    s_in_req  = 1'b1;
    for (int k = 0; k < 50 && s_out_req !== 1'b1; k++) @(negedge clk);
    check(s_out_req === 1'b1 && s_out_data === 8'hA5, "R3", "single out item", s_out_data, 8'hA5);
    check(s_in_ack === 1'b1, "R2", "single ack high", s_in_ack, 1);
    s_in_req  = 1'b0;
    s_in_data = 8'h5A;
    repeat (20) @(negedge clk);
    check(s_in_ack === 1'b1, "R8", "ack held while out_ack low", s_in_ack, 1);
    check(s_out_data === 8'hA5, "R5", "input change ignored", s_out_data, 8'hA5);
    s_out_ack = 1'b1;
    for (int k = 0; k < 50 && s_in_ack !== 1'b0; k++) @(negedge clk);
    check(s_in_ack === 1'b0, "R8", "ack falls after out_ack", s_in_ack, 0);
    for (int k = 0; k < 50 && s_out_req !== 1'b0; k++) @(negedge clk);
    check(s_out_req === 1'b0, "R10", "out_req falls after out_ack", s_out_req, 0);
    s_in_data = 8'h3C;
    s_in_req  = 1'b1;
    for (int k = 0; k < 50 && s_in_ack !== 1'b1; k++) @(negedge clk);
    check(s_in_ack === 1'b1 && s_out_ack === 1'b1, "R9", "capture with out_ack high", s_in_ack, 1);
    repeat (10) @(negedge clk);
    check(s_out_req === 1'b0, "R10", "out_req waits for out_ack low", s_out_req, 0);
    s_out_ack = 1'b0;
    for (int k = 0; k < 50 && s_out_req !== 1'b1; k++) @(negedge clk);
    check(s_out_req === 1'b1 && s_out_data === 8'h3C, "R3", "second single item", s_out_data, 8'h3C);
    s_out_ack = 1'b1;
    s_in_req  = 1'b0;
    for (int k = 0; k < 50 && s_out_req !== 1'b0; k++) @(negedge clk);
    s_out_ack = 1'b0;
    repeat (5) @(negedge clk);
    check(s_in_ack === 1'b0 && s_out_req === 1'b0, "R1", "single stage back to idle", s_in_ack, 0);

    summary();
    $finish;
  end
endmodule